// File: doc/BRIEF.md
# Instruction Cycle Sequencer

A multi-cycle control unit for a small accumulator machine. It steps through fetch, indirect-address resolution, execute and interrupt service. It does this by moving words between a program counter (PC), an instruction register (IR), a memory address register (MAR) and a memory buffer register (MBR). The MAR always drives the address bus and the MBR always drives the write data bus. Every memory read is issued in one cycle and its data is captured in the MBR on the following cycle.

An instruction word is 16 bits: bit 15 is the indirect flag, bits 14:12 the opcode and bits 11:0 the address field. The execute step handles load, add and store through a single accumulator, plus jump, return-from-interrupt and halt. An interrupt request is honoured only at the boundary after an execute step, and only while interrupts are enabled. The current PC is written to a fixed save word, control passes to a fixed handler address, and further interrupts stay blocked until the handler returns.

Top module: `icyc_sequencer`

## Requirements
- R1: While reset is high, both memory strobes and `halted` are low. After reset, the PC is 0x010, the accumulator is 0 and interrupts are enabled, so the first read strobe after reset carries address 0x010.
- R2: A fetch moves the PC into the MAR and then issues a read. It captures the returned word in the MBR one cycle later, copies it to the IR and adds one to the PC. Straight-line code is therefore fetched from consecutive addresses.
- R3: Opcodes in bits 14:12 are: 000 load, 001 store, 010 add, 011 jump, 100 return-from-interrupt, 111 halt. The codes 101 and 110 perform no operation and make no memory access in execute.
- R4: Load reads the word at the effective address into the accumulator. Add reads that word and adds it to the accumulator modulo 2^16.
- R5: Store makes exactly one write, of the accumulator, to the effective address.
- R6: Jump loads the PC with the effective address without any memory access during execute, so the next read strobe fetches from the target.
- R7: When bit 15 is set, the sequencer first reads the word at the address field. The low 12 bits of that word then become the effective address used by execute.
- R8: When the request line is high at the end of an execute step while interrupts are enabled, the sequencer writes the PC to address 0. That saved PC is the next sequential address, or the jump target if the step was a jump. It then loads the PC with 1 and disables interrupts.
- R9: Return-from-interrupt reads address 0, loads the PC from its low 12 bits and re-enables interrupts.
- R10: Halt stops the sequencer with `halted` high. After that no strobe is asserted and the request line is ignored until reset.
- R11: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_wdata | output | 16 | Write data (MBR) |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A jump updates the PC in the same cycle that ends its execute step, and that is also the cycle in which an interrupt request is sampled. The two therefore coincide whenever a request is pending as a jump completes. The bench holds the request high from reset so that the very first execute boundary is a jump. It then checks that address 0 receives the jump target rather than the address after the jump. A second scenario holds the request high for a whole program. The save count and the final saved PC there show that interrupts are masked inside the handler and re-enabled by the return.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = 3;
    localparam int PAD_W  = WORD_W - ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD  = 3'd0,
        OPC_STORE = 3'd1,
        OPC_ADD   = 3'd2,
        OPC_JUMP  = 3'd3,
        OPC_RETI  = 3'd4,
        OPC_NOPA  = 3'd5,
        OPC_NOPB  = 3'd6,
        OPC_HALT  = 3'd7
    } opc_t;

    typedef struct packed {
        logic  ind;
        opc_t  opc;
        addr_t field;
    } instr_t;

    typedef enum logic [4:0] {
        ST_F_MAR, ST_F_RD, ST_F_WAIT, ST_F_IR,
        ST_I_MAR, ST_I_RD, ST_I_WAIT, ST_I_IR,
        ST_X_START, ST_X_RD, ST_X_WAIT, ST_X_DONE, ST_X_WR,
        ST_INT_MBR, ST_INT_WR, ST_INT_VEC,
        ST_HALT
    } state_t;

    typedef enum logic [1:0] { MAR_FROM_PC, MAR_FROM_IR, MAR_FROM_MBR, MAR_FROM_SAVE } mar_src_t;
    typedef enum logic [1:0] { MBR_FROM_MEM, MBR_FROM_ACC, MBR_FROM_PC } mbr_src_t;
    typedef enum logic [1:0] { PC_FROM_IR, PC_FROM_MBR, PC_FROM_VEC } pc_src_t;
    typedef enum logic [1:0] { ACC_KEEP, ACC_LOAD, ACC_ADD } acc_op_t;

    // register-transfer control word produced by the sequencer every cycle
    typedef struct packed {
        logic     mar_ld;
        mar_src_t mar_src;
        logic     mbr_ld;
        mbr_src_t mbr_src;
        logic     ir_ld;
        logic     ir_field_ld;
        logic     pc_inc;
        logic     pc_ld;
        pc_src_t  pc_src;
        acc_op_t  acc_op;
        logic     ie_set;
        logic     ie_clr;
    } ctl_t;

    function automatic instr_t as_instr(word_t w);
        return instr_t'(w);
    endfunction

    function automatic word_t widen_addr(addr_t a);
        return {{PAD_W{1'b0}}, a};
    endfunction

    function automatic logic needs_operand(opc_t o);
        return (o == OPC_LOAD) || (o == OPC_ADD) || (o == OPC_RETI);
    endfunction

endpackage

// File: rtl/icyc_accum.sv
module icyc_accum
    import icyc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  acc_op_t op,
    input  word_t   operand,
    output word_t   acc
);
    word_t acc_q, acc_d;

    always_comb begin
        unique case (op)
            ACC_LOAD: acc_d = operand;
            ACC_ADD:  acc_d = acc_q + operand;
            default:  acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign acc = acc_q;

    assert_acc_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (op == ACC_ADD) |=> (acc_q == word_t'($past(acc_q) + $past(operand))));

endmodule

// File: rtl/icyc_datapath.sv
module icyc_datapath
    import icyc_pkg::*;
#(
    parameter addr_t RESET_PC  = 12'h010,
    parameter addr_t SAVE_ADDR = 12'h000,
    parameter addr_t VEC_ADDR  = 12'h001
) (
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  word_t mem_rdata,
    output addr_t mem_addr,
    output word_t mem_wdata,
    output opc_t  ir_opc,
    output logic  mbr_ind,
    output logic  ie
);
    addr_t pc_q, mar_q, ir_field_q;
    opc_t  ir_opc_q;
    word_t mbr_q, acc;
    logic  ie_q;

    addr_t mar_d, pc_d;
    word_t mbr_d;
    instr_t mbr_view;

    assign mbr_view = as_instr(mbr_q);

    always_comb begin
        unique case (ctl.mar_src)
            MAR_FROM_PC:  mar_d = pc_q;
            MAR_FROM_IR:  mar_d = ir_field_q;
            MAR_FROM_MBR: mar_d = mbr_view.field;
            default:      mar_d = SAVE_ADDR;
        endcase
    end

    always_comb begin
        unique case (ctl.mbr_src)
            MBR_FROM_ACC: mbr_d = acc;
            MBR_FROM_PC:  mbr_d = widen_addr(pc_q);
            default:      mbr_d = mem_rdata;
        endcase
    end

    always_comb begin
        unique case (ctl.pc_src)
            PC_FROM_IR:  pc_d = ir_field_q;
            PC_FROM_MBR: pc_d = mbr_view.field;
            default:     pc_d = VEC_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= RESET_PC;
            mar_q      <= '0;
            mbr_q      <= '0;
            ir_opc_q   <= OPC_NOPA;
            ir_field_q <= '0;
            ie_q       <= 1'b1;
        end else begin
            if (ctl.mar_ld) mar_q <= mar_d;
            if (ctl.mbr_ld) mbr_q <= mbr_d;
            if (ctl.ir_ld) begin
                ir_opc_q   <= mbr_view.opc;
                ir_field_q <= mbr_view.field;
            end else if (ctl.ir_field_ld) begin
                ir_field_q <= mbr_view.field;
            end
            if (ctl.pc_inc)     pc_q <= pc_q + 1'b1;
            else if (ctl.pc_ld) pc_q <= pc_d;
            if (ctl.ie_set)      ie_q <= 1'b1;
            else if (ctl.ie_clr) ie_q <= 1'b0;
        end
    end

    icyc_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .op      (ctl.acc_op),
        .operand (mbr_q),
        .acc     (acc)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign ir_opc    = ir_opc_q;
    assign mbr_ind   = mbr_view.ind;
    assign ie        = ie_q;

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.ir_ld |=> (pc_q == addr_t'($past(pc_q) + 1'b1)));

    assert_vector_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.pc_ld && ctl.pc_src == PC_FROM_VEC) |=> (pc_q == VEC_ADDR && !ie_q));

endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
    import icyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   irq,
    input  logic   ie,
    input  opc_t   ir_opc,
    input  logic   mbr_ind,
    output ctl_t   ctl,
    output logic   mem_rd,
    output logic   mem_wr,
    output state_t state
);
    state_t state_q, state_d;
    logic   exec_end;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_F_MAR;
        else     state_q <= state_d;
    end

    always_comb begin
        ctl      = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        exec_end = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_F_MAR: begin
                ctl.mar_ld  = 1'b1;
                ctl.mar_src = MAR_FROM_PC;
                state_d     = ST_F_RD;
            end
            ST_F_RD: begin
                mem_rd  = 1'b1;
                state_d = ST_F_WAIT;
            end
            ST_F_WAIT: begin
                ctl.mbr_ld  = 1'b1;
                ctl.mbr_src = MBR_FROM_MEM;
                state_d     = ST_F_IR;
            end
            ST_F_IR: begin
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
                state_d    = mbr_ind ? ST_I_MAR : ST_X_START;
            end
            ST_I_MAR: begin
                ctl.mar_ld  = 1'b1;
                ctl.mar_src = MAR_FROM_MBR;
                state_d     = ST_I_RD;
            end
            ST_I_RD: begin
                mem_rd  = 1'b1;
                state_d = ST_I_WAIT;
            end
            ST_I_WAIT: begin
                ctl.mbr_ld  = 1'b1;
                ctl.mbr_src = MBR_FROM_MEM;
                state_d     = ST_I_IR;
            end
            ST_I_IR: begin
                ctl.ir_field_ld = 1'b1;
                state_d         = ST_X_START;
            end
            ST_X_START: begin
                if (needs_operand(ir_opc)) begin
                    ctl.mar_ld  = 1'b1;
                    ctl.mar_src = (ir_opc == OPC_RETI) ? MAR_FROM_SAVE : MAR_FROM_IR;
                    state_d     = ST_X_RD;
                end else if (ir_opc == OPC_STORE) begin
                    ctl.mar_ld  = 1'b1;
                    ctl.mar_src = MAR_FROM_IR;
                    ctl.mbr_ld  = 1'b1;
                    ctl.mbr_src = MBR_FROM_ACC;
                    state_d     = ST_X_WR;
                end else if (ir_opc == OPC_HALT) begin
                    state_d = ST_HALT;
                end else begin
                    if (ir_opc == OPC_JUMP) begin
                        ctl.pc_ld  = 1'b1;
                        ctl.pc_src = PC_FROM_IR;
                    end
                    exec_end = 1'b1;
                end
            end
            ST_X_RD: begin
                mem_rd  = 1'b1;
                state_d = ST_X_WAIT;
            end
            ST_X_WAIT: begin
                ctl.mbr_ld  = 1'b1;
                ctl.mbr_src = MBR_FROM_MEM;
                state_d     = ST_X_DONE;
            end
            ST_X_DONE: begin
                unique case (ir_opc)
                    OPC_LOAD: ctl.acc_op = ACC_LOAD;
                    OPC_ADD:  ctl.acc_op = ACC_ADD;
                    default: begin
                        ctl.pc_ld  = 1'b1;
                        ctl.pc_src = PC_FROM_MBR;
                        ctl.ie_set = 1'b1;
                    end
                endcase
                exec_end = 1'b1;
            end
            ST_X_WR: begin
                mem_wr   = 1'b1;
                exec_end = 1'b1;
            end
            ST_INT_MBR: begin
                ctl.mbr_ld  = 1'b1;
                ctl.mbr_src = MBR_FROM_PC;
                ctl.mar_ld  = 1'b1;
                ctl.mar_src = MAR_FROM_SAVE;
                state_d     = ST_INT_WR;
            end
            ST_INT_WR: begin
                mem_wr  = 1'b1;
                state_d = ST_INT_VEC;
            end
            ST_INT_VEC: begin
                ctl.pc_ld  = 1'b1;
                ctl.pc_src = PC_FROM_VEC;
                ctl.ie_clr = 1'b1;
                state_d    = ST_F_MAR;
            end
            default: state_d = ST_HALT;
        endcase
        // request line is looked at only here, at the execute boundary
        if (exec_end) state_d = (irq && ie) ? ST_INT_MBR : ST_F_MAR;
    end

    assign state = state_q;

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |=> (state_q == ST_HALT && !mem_rd && !mem_wr));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (ctl.mbr_ld && ctl.mbr_src == MBR_FROM_MEM));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_INT_MBR) |-> $past(irq && ie));

    assert_reti_enable_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_X_DONE && ir_opc == OPC_RETI) |=> ie);

endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer
    import icyc_pkg::*;
#(
    parameter addr_t RESET_PC  = 12'h010,
    parameter addr_t SAVE_ADDR = 12'h000,
    parameter addr_t VEC_ADDR  = 12'h001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);
    ctl_t   ctl;
    state_t st;
    opc_t   ir_opc;
    logic   mbr_ind, ie;

    icyc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .irq     (irq),
        .ie      (ie),
        .ir_opc  (ir_opc),
        .mbr_ind (mbr_ind),
        .ctl     (ctl),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .state   (st)
    );

    icyc_datapath #(
        .RESET_PC  (RESET_PC),
        .SAVE_ADDR (SAVE_ADDR),
        .VEC_ADDR  (VEC_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ir_opc    (ir_opc),
        .mbr_ind   (mbr_ind),
        .ie        (ie)
    );

    assign halted = (st == ST_HALT);

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_save_target_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_INT_WR) |-> (mem_wr && mem_addr == SAVE_ADDR));

endmodule

// File: tb/icyc_sequencer_tb.sv
module icyc_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic        mem_rd, mem_wr, halted;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [15:0] img [0:1023];
    logic [15:0] mem [0:1023];
    logic [15:0] rd_q;
    logic [11:0] rd_log [0:63];
    int rd_n, wr_n, save_n, both_n;

    always #10 clk = ~clk;

    icyc_sequencer dut_i (
        .clk(clk), .rst(rst), .irq(irq),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
    );

    // synchronous memory, read data one cycle after the strobe
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= img[i];
            rd_q <= '0;
        end else begin
            if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
            if (mem_rd) rd_q <= mem[mem_addr[9:0]];
        end
    end
    assign mem_rdata = rd_q;

    always @(negedge clk) begin
        if (rst) begin
            rd_n = 0; wr_n = 0; save_n = 0; both_n = 0;
        end else begin
            if (mem_rd && rd_n < 64) begin rd_log[rd_n] = mem_addr; rd_n++; end
            if (mem_wr) wr_n++;
            if (mem_wr && mem_addr == 12'h000) save_n++;
            if (mem_rd && mem_wr) both_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 1024; i++) img[i] = 16'h0000;
    endtask

    task automatic start();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input int lim);
        int n = 0;
        while (!halted && n < lim) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_fetch();
        clear_img();
        img[12'h10] = 16'h0064; img[12'h11] = 16'h2065;
        img[12'h12] = 16'h1066; img[12'h13] = 16'h7000;
        img[100] = 16'd5; img[101] = 16'd7; img[102] = 16'hAAAA;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 rd low in reset", {31'd0, mem_rd}, 32'd0);
        chk("R1 wr low in reset", {31'd0, mem_wr}, 32'd0);
        chk("R1 halted low in reset", {31'd0, halted}, 32'd0);
        start();
        run_to_halt(400);
        chk("R1 first fetch addr", {20'd0, rd_log[0]}, 32'h10);
        chk("R2 second fetch addr", {20'd0, rd_log[2]}, 32'h11);
        chk("R2 third fetch addr", {20'd0, rd_log[4]}, 32'h12);
        chk("R2 read count", rd_n, 32'd6);
        chk("R4 load plus add", {16'd0, mem[102]}, 32'd12);
        chk("R5 single write", wr_n, 32'd1);
    endtask

    task automatic t_add_wrap_nop();
        clear_img();
        img[12'h10] = 16'h0064; img[12'h11] = 16'h5000; img[12'h12] = 16'h2065;
        img[12'h13] = 16'h1066; img[12'h14] = 16'h7000;
        img[100] = 16'hFFFF; img[101] = 16'd2;
        start();
        run_to_halt(400);
        chk("R4 add wraps", {16'd0, mem[102]}, 32'd1);
        chk("R3 nop makes no access", rd_n, 32'd7);
    endtask

    task automatic t_indirect();
        clear_img();
        img[12'h10] = 16'h8067; img[12'h11] = 16'h9068; img[12'h12] = 16'h7000;
        img[100] = 16'd5; img[103] = 16'd100; img[104] = 16'd105;
        start();
        run_to_halt(400);
        chk("R7 pointer read", {20'd0, rd_log[1]}, 32'd103);
        chk("R7 operand via pointer", {20'd0, rd_log[2]}, 32'd100);
        chk("R7 store pointer read", {20'd0, rd_log[4]}, 32'd104);
        chk("R7 indirect store data", {16'd0, mem[105]}, 32'd5);
    endtask

    task automatic t_jump();
        clear_img();
        img[12'h10] = 16'h3030; img[12'h11] = 16'h1066;
        img[12'h30] = 16'h0064; img[12'h31] = 16'h1067; img[12'h32] = 16'h7000;
        img[100] = 16'd5; img[102] = 16'hAAAA;
        start();
        run_to_halt(400);
        chk("R6 fetch from target", {20'd0, rd_log[1]}, 32'h30);
        chk("R6 skipped store", {16'd0, mem[102]}, 32'hAAAA);
        chk("R6 target code ran", {16'd0, mem[103]}, 32'd5);
    endtask

    task automatic t_irq_on_jump();
        clear_img();
        img[1] = 16'h3040; img[12'h40] = 16'h4000;
        img[12'h10] = 16'h3030; img[12'h30] = 16'h1066; img[12'h31] = 16'h7000;
        img[102] = 16'hAAAA;
        irq = 1'b1;
        start();
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (mem_wr && mem_addr == 12'h000) begin irq = 1'b0; break; end
        end
        irq = 1'b0;
        run_to_halt(400);
        chk("R8 saved jump target", {16'd0, mem[0]}, 32'h30);
        chk("R8 one save", save_n, 32'd1);
        chk("R8 resumed after return", {16'd0, mem[102]}, 32'd0);
    endtask

    task automatic t_irq_held();
        clear_img();
        img[1] = 16'h3040; img[12'h40] = 16'h106E; img[12'h41] = 16'h4000;
        img[12'h10] = 16'h0064; img[12'h11] = 16'h1066; img[12'h12] = 16'h7000;
        img[100] = 16'd5;
        irq = 1'b1;
        start();
        run_to_halt(800);
        irq = 1'b0;
        chk("R8 masked in handler, R9 re-enabled: saves", save_n, 32'd2);
        chk("R9 last saved pc", {16'd0, mem[0]}, 32'h12);
        chk("R8 handler ran", {16'd0, mem[110]}, 32'd5);
        chk("R9 main resumed", {16'd0, mem[102]}, 32'd5);
        chk("R8 total writes", wr_n, 32'd5);
        chk("R11 no overlap of strobes", both_n, 32'd0);
    endtask

    task automatic t_halt_hold();
        clear_img();
        img[12'h10] = 16'h7000;
        start();
        run_to_halt(100);
        irq = 1'b1;
        repeat (50) @(negedge clk);
        chk("R10 halted stays", {31'd0, halted}, 32'd1);
        chk("R10 no further reads", rd_n, 32'd1);
        chk("R10 irq ignored", wr_n, 32'd0);
        irq = 1'b0;
    endtask

    initial begin
        t_reset_fetch();
        t_add_wrap_nop();
        t_indirect();
        t_jump();
        t_irq_on_jump();
        t_irq_held();
        t_halt_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule